// File: doc/BRIEF.md
# Circular transfer record buffer

This block stores control transfer records in a circular physical array and presents them to software as a stack ordered by age. Each record has a source word, a target word and a metadata word. In the source word, bit 0 is the valid flag. In the target word, bit 0 is the mispredict flag. A write pointer marks the physical slot that is written next. Logical entry X is the physical slot `(ptr - X - 1) mod depth`, so logical entry 0 is always the newest record.

The upstream qualification logic presents a ready-made record together with a 2-bit kind. The kind encodings are 0 = other, 1 = call, 2 = return and 3 = swap. The block records that push unless the frozen input is high.

With the stack emulation mode off, every push is recorded in the same way. With it on, the block behaves as follows:
- A call is recorded normally.
- A return steps the pointer back and invalidates the slot the pointer now addresses.
- A swap overwrites logical entry 0 and leaves the pointer where it is.
- Any other kind is dropped.

Software can select the depth, write the pointer, read and write logical entries by index, and clear the whole buffer.

Top module: `xfer_rec_buf`

## Requirements
- R1: After reset, the pointer reads 0, the depth code reads 000, and every logical entry reads 0 in all three words.
- R2: The depth code maps 000→16, 001→32, 010→64, 011→128 and 100→256 entries. A written code above the largest one the physical array supports, including the reserved codes 11x, is stored as that largest code. The active depth sets where the pointer wraps.
- R3: A normal recorded push writes the physical slot at the pointer, sets its valid bit and increments the pointer. Logical entry X then returns the record pushed X pushes earlier.
- R4: An increment from depth−1 wraps the pointer to 0. Once depth+1 records have been pushed, the oldest one is lost.
- R5: A logical index at or above the current depth (up to 255) reads 0 in all words, and a software write to it changes no entry.
- R6: Pointer bits above those needed for depth−1 read as 0, including after a software write of a wider value. A decrement from 0 wraps to depth−1.
- R7: In stack emulation mode, a call (kind 1) records normally. A return (kind 2) decrements the pointer and clears the valid bit of the slot at the new pointer. A swap (kind 3) overwrites logical entry 0 without moving the pointer. Kind 0 changes nothing.
- R8: After a clear, every logical entry reads 0 in all words until the next recorded push, and that push is then visible at logical entry 0.
- R9: While frozen is high, a push changes neither the pointer nor any entry.
- R10: When a software pointer write and a recorded push happen in the same cycle, the push wins. The record lands at the old pointer, and the pointer becomes the old pointer plus one.
- R11: A software write with byte mask bits {meta, target, source} writes the selected words of a logical entry. The valid bit comes from bit 0 of the written source word. An entry whose valid bit is 0 reads 0 in all three words.
- R12: On a push, bit 0 of the pushed source word is stored as 1 (valid), and bit 0 of the stored target word takes the mispredict input, whatever the pushed word held there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frozen_i | input | 1 | Blocks all hardware updates |
| ras_mode_i | input | 1 | Return-address-stack emulation mode |
| push_i | input | 1 | Qualified transfer presented this cycle |
| push_kind_i | input | 2 | 0 other, 1 call, 2 return, 3 swap |
| push_src_i | input | PC_W | Source PC (bit 0 ignored) |
| push_tgt_i | input | PC_W | Target PC (bit 0 ignored) |
| push_misp_i | input | 1 | Mispredict flag |
| push_meta_i | input | META_W | Metadata word |
| clear_i | input | 1 | Invalidate all entries |
| depth_wr_i | input | 1 | Depth code write strobe |
| depth_code_i | input | 3 | Depth code to write |
| depth_code_o | output | 3 | Stored depth code |
| wrptr_wr_i | input | 1 | Pointer write strobe |
| wrptr_i | input | 8 | Pointer write value |
| wrptr_o | output | 8 | Current write pointer |
| ent_idx_i | input | 8 | Logical entry index for read and write |
| ent_we_i | input | 3 | Word write mask: bit0 source, bit1 target, bit2 meta |
| ent_src_i | input | PC_W | Source word to write |
| ent_tgt_i | input | PC_W | Target word to write |
| ent_meta_i | input | META_W | Metadata word to write |
| ent_src_o | output | PC_W | Source word of the indexed entry |
| ent_tgt_o | output | PC_W | Target word of the indexed entry |
| ent_meta_o | output | META_W | Metadata word of the indexed entry |

## Verification
The hardest state to reach from the ports is a wrap in both directions. For the forward wrap, the bench starts from a non-zero pointer and pushes depth+1 records, so the pointer crosses depth−1 mid-sequence and the oldest record is overwritten. For the backward wrap, the bench writes the pointer to 0 and then issues an emulated return, so the decrement has to produce depth−1. The bench also aims a software write at an out-of-range index that aliases the physical slot of logical entry 0, which shows that the range gate protects live data. Finally, it drives a pointer write and a push in the same cycle to confirm their priority.

// File: rtl/xfer_rec_pkg.sv
package xfer_rec_pkg;
  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_CALL  = 2'd1,
    KIND_RET   = 2'd2,
    KIND_SWAP  = 2'd3
  } xfer_kind_e;

  localparam int LIDX_W     = 8;   // logical index / pointer port width
  localparam int CODE_W     = 3;
  localparam int MIN_LOG2   = 4;   // smallest depth is 16
endpackage

// File: rtl/xfer_rec_depth.sv
module xfer_rec_depth
  import xfer_rec_pkg::*;
#(
  parameter int PIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic [PIDX_W-1:0] mask_o,
  output logic [8:0]        depth_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(PIDX_W - MIN_LOG2);

  logic [CODE_W-1:0] code_q, code_n;

  always_comb begin
    code_n = code_q;
    if (wr_i) code_n = (code_i > MAX_CODE) ? MAX_CODE : code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_n;
  end

  assign code_o  = code_q;
  assign depth_o = 9'd16 << code_q;
  assign mask_o  = PIDX_W'(depth_o - 9'd1);

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= MAX_CODE);
  // R2
  code_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && code_i <= MAX_CODE) |=> code_q == $past(code_i));
endmodule

// File: rtl/xfer_rec_ptr.sv
module xfer_rec_ptr #(
  parameter int PIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              sw_we_i,
  input  logic [PIDX_W-1:0] sw_val_i,
  input  logic [PIDX_W-1:0] mask_i,
  output logic [PIDX_W-1:0] ptr_o
);
  logic [PIDX_W-1:0] ptr_q, ptr_n;

  assign ptr_o = ptr_q & mask_i;

  always_comb begin
    if (inc_i)        ptr_n = (ptr_o + 1'b1) & mask_i;
    else if (dec_i)   ptr_n = (ptr_o - 1'b1) & mask_i;
    else if (sw_we_i) ptr_n = sw_val_i & mask_i;
    else              ptr_n = ptr_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  // R4
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && ptr_o == mask_i) |=> ptr_q == '0);
  // R6
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && ptr_o == '0) |=> ptr_q == $past(mask_i));
  // R10
  push_over_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && sw_we_i && ptr_o != mask_i) |=> ptr_q == $past(ptr_o) + 1'b1);
endmodule

// File: rtl/xfer_rec_store.sv
module xfer_rec_store #(
  parameter int ENTRIES = 32,
  parameter int PC_W    = 32,
  parameter int META_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       hw_we_i,
  input  logic                       hw_inv_i,
  input  logic [$clog2(ENTRIES)-1:0] hw_idx_i,
  input  logic [PC_W-1:0]            hw_src_i,
  input  logic [PC_W-1:0]            hw_tgt_i,
  input  logic [META_W-1:0]          hw_meta_i,
  input  logic [2:0]                 sw_we_i,
  input  logic [$clog2(ENTRIES)-1:0] sw_idx_i,
  input  logic [PC_W-1:0]            sw_src_i,
  input  logic [PC_W-1:0]            sw_tgt_i,
  input  logic [META_W-1:0]          sw_meta_i,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx_i,
  output logic                       rd_valid_o,
  output logic [PC_W-1:0]            rd_src_o,
  output logic [PC_W-1:0]            rd_tgt_o,
  output logic [META_W-1:0]          rd_meta_o
);
  logic [ENTRIES-1:0] valid_q, valid_n;
  logic [PC_W-2:0]    src_q  [ENTRIES];
  logic [PC_W-1:0]    tgt_q  [ENTRIES];
  logic [META_W-1:0]  meta_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic hw_hit, sw_hit;
    assign hw_hit = (hw_idx_i == i[$clog2(ENTRIES)-1:0]);
    assign sw_hit = (sw_idx_i == i[$clog2(ENTRIES)-1:0]);

    always_comb begin
      valid_n[i] = valid_q[i];
      if (clr_i)                  valid_n[i] = 1'b0;
      if (sw_we_i[0] && sw_hit)   valid_n[i] = sw_src_i[0];
      if (hw_inv_i && hw_hit)     valid_n[i] = 1'b0;
      if (hw_we_i && hw_hit)      valid_n[i] = hw_src_i[0];
    end

    always_ff @(posedge clk) begin
      if (hw_we_i && hw_hit)         src_q[i] <= hw_src_i[PC_W-1:1];
      else if (sw_we_i[0] && sw_hit) src_q[i] <= sw_src_i[PC_W-1:1];
    end
    always_ff @(posedge clk) begin
      if (hw_we_i && hw_hit)         tgt_q[i] <= hw_tgt_i;
      else if (sw_we_i[1] && sw_hit) tgt_q[i] <= sw_tgt_i;
    end
    always_ff @(posedge clk) begin
      if (hw_we_i && hw_hit)         meta_q[i] <= hw_meta_i;
      else if (sw_we_i[2] && sw_hit) meta_q[i] <= sw_meta_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_n;
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_src_o   = {src_q[rd_idx_i], valid_q[rd_idx_i]};
  assign rd_tgt_o   = tgt_q[rd_idx_i];
  assign rd_meta_o  = meta_q[rd_idx_i];

  // R3
  push_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we_i && hw_src_i[0]) |=> valid_q[$past(hw_idx_i)]);
  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hw_we_i && sw_we_i == 3'b000) |=> valid_q == '0);
  // R7
  ret_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_inv_i && !hw_we_i && !(sw_we_i[0] && sw_idx_i == hw_idx_i))
      |=> !valid_q[$past(hw_idx_i)]);
endmodule

// File: rtl/xfer_rec_buf.sv
module xfer_rec_buf
  import xfer_rec_pkg::*;
#(
  parameter int PHYS_ENTRIES = 32,
  parameter int PC_W         = 32,
  parameter int META_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frozen_i,
  input  logic              ras_mode_i,
  input  logic              push_i,
  input  logic [1:0]        push_kind_i,
  input  logic [PC_W-1:0]   push_src_i,
  input  logic [PC_W-1:0]   push_tgt_i,
  input  logic              push_misp_i,
  input  logic [META_W-1:0] push_meta_i,
  input  logic              clear_i,
  input  logic              depth_wr_i,
  input  logic [2:0]        depth_code_i,
  output logic [2:0]        depth_code_o,
  input  logic              wrptr_wr_i,
  input  logic [7:0]        wrptr_i,
  output logic [7:0]        wrptr_o,
  input  logic [7:0]        ent_idx_i,
  input  logic [2:0]        ent_we_i,
  input  logic [PC_W-1:0]   ent_src_i,
  input  logic [PC_W-1:0]   ent_tgt_i,
  input  logic [META_W-1:0] ent_meta_i,
  output logic [PC_W-1:0]   ent_src_o,
  output logic [PC_W-1:0]   ent_tgt_o,
  output logic [META_W-1:0] ent_meta_o
);
  localparam int PIDX_W = $clog2(PHYS_ENTRIES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic [PIDX_W-1:0] mask, ptr, ptr_m1, phys_idx, hw_idx;
  logic [8:0]        depth;
  logic              in_range, rd_valid;
  logic              act, rec_norm, ras_ret, ras_swap, hw_we;
  logic [PC_W-1:0]   st_src, st_tgt;
  logic [META_W-1:0] st_meta;
  xfer_kind_e        kind;

  xfer_rec_depth #(.PIDX_W(PIDX_W)) u_depth (
    .clk(clk), .rst_n(rst_s), .wr_i(depth_wr_i), .code_i(depth_code_i),
    .code_o(depth_code_o), .mask_o(mask), .depth_o(depth));

  // hardware action decode
  assign kind     = xfer_kind_e'(push_kind_i);
  assign act      = push_i && !frozen_i;
  assign rec_norm = act && (!ras_mode_i || kind == KIND_CALL);
  assign ras_ret  = act && ras_mode_i && kind == KIND_RET;
  assign ras_swap = act && ras_mode_i && kind == KIND_SWAP;
  assign hw_we    = rec_norm || ras_swap;

  xfer_rec_ptr #(.PIDX_W(PIDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_s), .inc_i(rec_norm), .dec_i(ras_ret),
    .sw_we_i(wrptr_wr_i), .sw_val_i(wrptr_i[PIDX_W-1:0]), .mask_i(mask),
    .ptr_o(ptr));

  assign ptr_m1   = (ptr - 1'b1) & mask;
  assign hw_idx   = rec_norm ? ptr : ptr_m1;
  assign in_range = {1'b0, ent_idx_i} < depth;
  assign phys_idx = (ptr - ent_idx_i[PIDX_W-1:0] - 1'b1) & mask;

  xfer_rec_store #(.ENTRIES(PHYS_ENTRIES), .PC_W(PC_W), .META_W(META_W)) u_store (
    .clk(clk), .rst_n(rst_s), .clr_i(clear_i),
    .hw_we_i(hw_we), .hw_inv_i(ras_ret), .hw_idx_i(hw_idx),
    .hw_src_i(push_src_i | PC_W'(1)),
    .hw_tgt_i((push_tgt_i & ~PC_W'(1)) | PC_W'(push_misp_i)),
    .hw_meta_i(push_meta_i),
    .sw_we_i(ent_we_i & {3{in_range}}), .sw_idx_i(phys_idx),
    .sw_src_i(ent_src_i), .sw_tgt_i(ent_tgt_i), .sw_meta_i(ent_meta_i),
    .rd_idx_i(phys_idx), .rd_valid_o(rd_valid),
    .rd_src_o(st_src), .rd_tgt_o(st_tgt), .rd_meta_o(st_meta));

  assign wrptr_o    = LIDX_W'(ptr);
  assign ent_src_o  = (in_range && rd_valid) ? st_src  : '0;
  assign ent_tgt_o  = (in_range && rd_valid) ? st_tgt  : '0;
  assign ent_meta_o = (in_range && rd_valid) ? st_meta : '0;

  // R9
  frozen_ptr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (frozen_i && !wrptr_wr_i && !depth_wr_i) |=> $stable(wrptr_o));
  // R5
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !in_range |-> (ent_src_o == '0 && ent_meta_o == '0));
  // R7
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ras_swap && !wrptr_wr_i && !depth_wr_i) |=> $stable(wrptr_o));
endmodule

// File: tb/tb_xfer_rec_buf.sv
module tb_xfer_rec_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frozen_i = 0, ras_mode_i = 0, push_i = 0, push_misp_i = 0;
  logic [1:0]  push_kind_i = 0;
  logic [31:0] push_src_i = 0, push_tgt_i = 0, push_meta_i = 0;
  logic        clear_i = 0, depth_wr_i = 0, wrptr_wr_i = 0;
  logic [2:0]  depth_code_i = 0, ent_we_i = 0;
  logic [7:0]  wrptr_i = 0, ent_idx_i = 0;
  logic [31:0] ent_src_i = 0, ent_tgt_i = 0, ent_meta_i = 0;
  logic [2:0]  depth_code_o;
  logic [7:0]  wrptr_o;
  logic [31:0] ent_src_o, ent_tgt_o, ent_meta_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xfer_rec_buf dut (.*);

  function automatic logic [31:0] s_of(int n); return 32'h1000_0000 + 32'(n * 16); endfunction
  function automatic logic [31:0] t_of(int n); return 32'h2000_0000 + 32'(n * 16); endfunction
  function automatic logic [31:0] m_of(int n); return 32'hA000_0000 + 32'(n); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(int n, logic [1:0] kind, logic misp = 0, logic [31:0] tgt_or = 0);
    @(negedge clk);
    push_i = 1; push_kind_i = kind; push_src_i = s_of(n);
    push_tgt_i = t_of(n) | tgt_or; push_misp_i = misp; push_meta_i = m_of(n);
    @(negedge clk);
    push_i = 0;
  endtask

  task automatic rd(int idx);
    ent_idx_i = 8'(idx);
    #1;
  endtask

  task automatic set_ptr(logic [7:0] v);
    @(negedge clk); wrptr_wr_i = 1; wrptr_i = v;
    @(negedge clk); wrptr_wr_i = 0;
  endtask

  task automatic set_depth(logic [2:0] c);
    @(negedge clk); depth_wr_i = 1; depth_code_i = c;
    @(negedge clk); depth_wr_i = 0;
  endtask

  task automatic t_reset;
    chk("R1 ptr", 32'(wrptr_o), 0);
    chk("R1 depth", 32'(depth_code_o), 0);
    rd(0);
    chk("R1 src", ent_src_o, 0);
    chk("R1 meta", ent_meta_o, 0);
  endtask

  task automatic t_depth;
    set_depth(3'b100); chk("R2 clamp 100", 32'(depth_code_o), 1);
    set_depth(3'b111); chk("R2 clamp 11x", 32'(depth_code_o), 1);
    set_depth(3'b000); chk("R2 code 000", 32'(depth_code_o), 0);
  endtask

  task automatic t_push;
    push(1, 2'd0);
    push(2, 2'd0, 1'b0, 32'h1);
    push(3, 2'd0, 1'b1);
    chk("R3 ptr", 32'(wrptr_o), 3);
    rd(0);
    chk("R3/R12 src valid", ent_src_o, s_of(3) | 1);
    chk("R12 misp set", ent_tgt_o, t_of(3) | 1);
    chk("R3 meta newest", ent_meta_o, m_of(3));
    rd(1); chk("R12 tgt bit0 dropped", ent_tgt_o, t_of(2));
    rd(2); chk("R3 meta oldest", ent_meta_o, m_of(1));
    rd(3); chk("R3 empty slot", ent_src_o, 0);
  endtask

  task automatic t_wrap;
    for (int k = 0; k < 17; k++) begin
      push(10 + k, 2'd0);
      if (k == 12) chk("R4 wrap to 0", 32'(wrptr_o), 0);
    end
    chk("R4 ptr", 32'(wrptr_o), 4);
    rd(0);  chk("R4 newest", ent_meta_o, m_of(26));
    rd(15); chk("R4 oldest kept", ent_meta_o, m_of(11));
    rd(16); chk("R5 oob read", ent_src_o, 0);
  endtask

  task automatic t_oob;
    @(negedge clk);
    ent_idx_i = 8'd16; ent_we_i = 3'b101; ent_src_i = 32'hDEAD_0001; ent_meta_i = 32'hDEAD_BEEF;
    @(negedge clk); ent_we_i = 0;
    rd(0);  chk("R5 oob write ignored", ent_meta_o, m_of(26));
    rd(16); chk("R5 oob still zero", ent_meta_o, 0);
  endtask

  task automatic t_sw_entry;
    @(negedge clk);
    ent_idx_i = 8'd2; ent_we_i = 3'b001; ent_src_i = 32'h0000_1234;
    @(negedge clk); ent_we_i = 0;
    rd(2);
    chk("R11 invalid tgt", ent_tgt_o, 0);
    chk("R11 invalid meta", ent_meta_o, 0);
    @(negedge clk);
    ent_idx_i = 8'd2; ent_we_i = 3'b111;
    ent_src_i = 32'h5555_0001; ent_tgt_i = 32'h6666_0002; ent_meta_i = 32'h7777_0003;
    @(negedge clk); ent_we_i = 0;
    rd(2);
    chk("R11 src", ent_src_o, 32'h5555_0001);
    chk("R11 tgt", ent_tgt_o, 32'h6666_0002);
    chk("R11 meta", ent_meta_o, 32'h7777_0003);
  endtask

  task automatic t_prio;
    @(negedge clk);
    wrptr_wr_i = 1; wrptr_i = 8'd9;
    push_i = 1; push_kind_i = 0; push_src_i = s_of(60); push_tgt_i = t_of(60);
    push_misp_i = 0; push_meta_i = m_of(60);
    @(negedge clk); wrptr_wr_i = 0; push_i = 0;
    chk("R10 push wins ptr", 32'(wrptr_o), 5);
    rd(0); chk("R10 push recorded", ent_meta_o, m_of(60));
  endtask

  task automatic t_clear;
    @(negedge clk); clear_i = 1;
    @(negedge clk); clear_i = 0;
    rd(0);
    chk("R8 src", ent_src_o, 0);
    chk("R8 tgt", ent_tgt_o, 0);
    chk("R8 meta", ent_meta_o, 0);
    rd(1); chk("R8 older", ent_src_o, 0);
    push(61, 2'd0);
    rd(0); chk("R8 new push visible", ent_meta_o, m_of(61));
    rd(1); chk("R8 older stays clear", ent_src_o, 0);
  endtask

  task automatic t_ras;
    set_ptr(8'd5);
    ras_mode_i = 1;
    push(40, 2'd1);
    push(41, 2'd1);
    chk("R7 call ptr", 32'(wrptr_o), 7);
    push(99, 2'd2);
    chk("R7 ret ptr", 32'(wrptr_o), 6);
    rd(0);  chk("R7 ret exposes older", ent_meta_o, m_of(40));
    rd(15); chk("R7 ret invalidates", ent_src_o, 0);
    push(42, 2'd3);
    chk("R7 swap ptr", 32'(wrptr_o), 6);
    rd(0); chk("R7 swap meta", ent_meta_o, m_of(42));
    rd(1); chk("R7 swap no push-down", ent_src_o, 0);
    push(43, 2'd0);
    chk("R7 other ptr", 32'(wrptr_o), 6);
    rd(0); chk("R7 other ignored", ent_meta_o, m_of(42));
  endtask

  task automatic t_ptr;
    set_ptr(8'hFF);
    chk("R6 high bits zero", 32'(wrptr_o), 32'h0F);
    set_ptr(8'h00);
    push(98, 2'd2);
    chk("R6 dec wrap", 32'(wrptr_o), 32'h0F);
    ras_mode_i = 0;
  endtask

  task automatic t_frozen;
    frozen_i = 1;
    push(70, 2'd0);
    chk("R9 ptr held", 32'(wrptr_o), 32'h0F);
    rd(0); chk("R9 entry held", ent_src_o, 0);
    frozen_i = 0;
  endtask

  task automatic t_depth32;
    set_depth(3'b001);
    push(80, 2'd0);
    chk("R2 depth 32 no wrap", 32'(wrptr_o), 16);
    rd(0);  chk("R2 depth 32 record", ent_meta_o, m_of(80));
    rd(32); chk("R5 beyond 32", ent_src_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_depth;
    t_push;
    t_wrap;
    t_oob;
    t_sw_entry;
    t_prio;
    t_clear;
    t_ras;
    t_ptr;
    t_frozen;
    t_depth32;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule